// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt requests from a set of sources and decides whether the processor core should be interrupted, and at which vector address. Each source has a sticky request flag, a per-source enable and a priority bit. The low-numbered sources are core sources and the rest are peripheral sources. A control register holds a mode bit and two global enable bits. The meaning of the two global enables depends on the mode bit.

With the mode bit set, the controller runs two priority levels. High-level sources are taken at vector 0x000008 and low-level sources at vector 0x000018, and a high-level request can pre-empt a running low-level handler. With the mode bit clear, the controller runs in a single-level compatibility mode. The upper enable is a global enable and the lower enable gates the peripheral sources. Every interrupt goes to 0x000008, and the priority bits have no effect.

The core acknowledges a request with `irq_ack` and ends a handler with `irq_ret`. The controller clears the global enable of the level it hands out and restores it on return. It keeps a two-entry record of the active levels so that it can nest handlers.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the flags, the enables, the priority bits and all three control bits are zero, and `irq_req` is low.
- R2: A one-cycle pulse on `src_pulse[i]` sets flag i, and the flag stays set. A write to address 1 loads the flag register from `wr_data`. A source that pulses in the same cycle as that write ends up with its flag set.
- R3: A source can request only when its flag and its own enable are set, together with the global enable that applies to it. The enables are written at address 2 and the priority bits at address 3, bit i for source i.
- R4: When control bit 0 is clear (compatibility mode), control bit 1 enables every source. Peripheral sources (indices at or above N_CORE) also need control bit 2. The vector is 0x000008, and the priority bits are ignored.
- R5: When control bit 0 is set (priority mode), sources with their priority bit set need control bit 1 and vector to 0x000008. Sources with their priority bit clear need control bit 2 and vector to 0x000018.
- R6: When high- and low-level requests are pending together, the high-level vector is presented.
- R7: While `irq_req` is high and no acknowledge occurs, `irq_vec` and `irq_level` hold their values.
- R8: On an acknowledge, the global enable of the taken level is cleared: control bit 1 for the high level and for compatibility mode, control bit 2 for the low level. `glb_en_o` reports {bit 2, bit 1}. On `irq_ret`, the enable of the most recently taken level is set again.
- R9: A high-level request pre-empts a running low-level handler. A low-level request is never raised while a high-level handler is active. Returns restore the enables in reverse order of entry.
- R10: `irq_req` is registered. It rises on the second rising edge after a flag-setting pulse is sampled, and it drops in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | NSRC | One-cycle request pulses from the sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 flags, 2 enables, 3 priorities |
| wr_data | input | NSRC | Write data |
| irq_ack | input | 1 | Core takes the presented interrupt |
| irq_ret | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector address for the request |
| irq_level | output | 1 | 1 when the presented request is high level |
| flags_o | output | NSRC | Current request flags |
| glb_en_o | output | 2 | Global enables {lower, upper} |

## Verification
The assertions assume the core acknowledges only while `irq_req` is high, and never raises `irq_ack` and `irq_ret` in the same cycle. They also assume `irq_ret` comes only while a handler is active, software never re-enables a level from inside its own handler, and no source pulses during reset. The bench drives acknowledges only after it has observed the request. It clears the flag of the serviced source before each return, and it drives the control register only when no handler is open. A sweep covers every combination of mode, global enables, source index, priority bit and enable for a single flagged source.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } irq_lvl_e;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_FLAG = 2'd1,
    RA_ENAB = 2'd2,
    RA_PRIO = 2'd3
  } reg_addr_e;

  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_GHI_BIT  = 1;
  localparam int CTRL_GLO_BIT  = 2;

  localparam int NEST_DEPTH = 2;
  localparam int DEPTH_W    = $clog2(NEST_DEPTH + 1);

  function automatic irq_lvl_e pick_level(input logic hi_pend, input logic lo_pend);
    if (hi_pend || !lo_pend) return LVL_HI;
    return LVL_LO;
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [NSRC-1:0] wr_data,
  output logic [NSRC-1:0] flags_q,
  output logic [NSRC-1:0] enab_q,
  output logic [NSRC-1:0] prio_q
);

  logic wr_flag, wr_enab, wr_prio;

  assign wr_flag = wr_en && (wr_addr == RA_FLAG);
  assign wr_enab = wr_en && (wr_addr == RA_ENAB);
  assign wr_prio = wr_en && (wr_addr == RA_PRIO);

  // A pulse always wins over a clearing write in the same cycle.
  function automatic logic flag_next(input logic cur, input logic wr,
                                     input logic wbit, input logic pulse);
    return (wr ? wbit : cur) | pulse;
  endfunction

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[i] <= 1'b0;
        enab_q[i]  <= 1'b0;
        prio_q[i]  <= 1'b0;
      end else begin
        flags_q[i] <= flag_next(flags_q[i], wr_flag, wr_data[i], src_pulse[i]);
        if (wr_enab) enab_q[i] <= wr_data[i];
        if (wr_prio) prio_q[i] <= wr_data[i];
      end
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_CORE   = 4,
  parameter int N_PERIPH = 4,
  localparam int NSRC    = N_CORE + N_PERIPH
) (
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] enab,
  input  logic [NSRC-1:0] prio,
  input  logic            prio_mode,
  input  logic            gen_hi,
  input  logic            gen_lo,
  input  logic            hi_active,
  output logic            hi_pend,
  output logic            lo_pend,
  output logic            any_pend,
  output irq_lvl_e        sel_lvl
);

  localparam logic [NSRC-1:0] PERIPH_MASK = {{N_PERIPH{1'b1}}, {N_CORE{1'b0}}};

  logic [NSRC-1:0] live;
  logic [NSRC-1:0] compat_mask;
  logic            pm_hi, pm_lo, cm_req;

  assign live        = flags & enab;
  assign compat_mask = gen_lo ? {NSRC{1'b1}} : ~PERIPH_MASK;

  // Priority mode: each global bit gates its own level.
  assign pm_hi = prio_mode && gen_hi && (|(live & prio));
  assign pm_lo = prio_mode && gen_lo && !hi_active && (|(live & ~prio));

  // Compatibility mode: one level, lower bit gates peripherals only.
  assign cm_req = !prio_mode && gen_hi && (|(live & compat_mask));

  assign hi_pend  = pm_hi || cm_req;
  assign lo_pend  = pm_lo;
  assign any_pend = hi_pend || lo_pend;
  assign sel_lvl  = pick_level(hi_pend, lo_pend);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic [2:0]         ctrl_data,
  input  logic               take,
  input  irq_lvl_e           take_lvl,
  input  logic               ret,
  output logic               prio_mode,
  output logic               gen_hi,
  output logic               gen_lo,
  output logic               hi_active,
  output logic [DEPTH_W-1:0] depth
);

  logic [NEST_DEPTH-1:0] lvl_hi_q;
  logic [DEPTH_W-1:0]    depth_q;
  logic                  mode_q, ghi_q, glo_q;
  logic                  mode_d, ghi_d, glo_d;
  logic                  push, pop, top_hi;

  assign push = take && (depth_q != DEPTH_W'(NEST_DEPTH));
  assign pop  = ret && !take && (depth_q != '0);

  always_comb begin
    top_hi = 1'b0;
    for (int i = 0; i < NEST_DEPTH; i++)
      if (depth_q == DEPTH_W'(i + 1)) top_hi = lvl_hi_q[i];
  end

  always_comb begin
    hi_active = 1'b0;
    for (int i = 0; i < NEST_DEPTH; i++)
      if ((DEPTH_W'(i) < depth_q) && lvl_hi_q[i]) hi_active = 1'b1;
  end

  // Software write first, then the take/return update of one enable.
  always_comb begin
    mode_d = mode_q;
    ghi_d  = ghi_q;
    glo_d  = glo_q;
    if (wr_ctrl) begin
      mode_d = ctrl_data[CTRL_MODE_BIT];
      ghi_d  = ctrl_data[CTRL_GHI_BIT];
      glo_d  = ctrl_data[CTRL_GLO_BIT];
    end
    if (take) begin
      if (take_lvl == LVL_HI) ghi_d = 1'b0;
      else                    glo_d = 1'b0;
    end else if (pop) begin
      if (top_hi) ghi_d = 1'b1;
      else        glo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      ghi_q    <= 1'b0;
      glo_q    <= 1'b0;
      depth_q  <= '0;
      lvl_hi_q <= '0;
    end else begin
      mode_q <= mode_d;
      ghi_q  <= ghi_d;
      glo_q  <= glo_d;
      for (int i = 0; i < NEST_DEPTH; i++)
        if (push && (depth_q == DEPTH_W'(i))) lvl_hi_q[i] <= (take_lvl == LVL_HI);
      if (push)     depth_q <= depth_q + DEPTH_W'(1);
      else if (pop) depth_q <= depth_q - DEPTH_W'(1);
    end
  end

  assign prio_mode = mode_q;
  assign gen_hi    = ghi_q;
  assign gen_lo    = glo_q;
  assign depth     = depth_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int              N_CORE   = 4,
  parameter int              N_PERIPH = 4,
  parameter int              VEC_W    = 24,
  parameter logic [VEC_W-1:0] HI_VEC  = 24'h000008,
  parameter logic [VEC_W-1:0] LO_VEC  = 24'h000018,
  localparam int             NSRC     = N_CORE + N_PERIPH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_pulse,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NSRC-1:0]  wr_data,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_level,
  output logic [NSRC-1:0]  flags_o,
  output logic [1:0]       glb_en_o
);

  logic [NSRC-1:0]    flags, enab, prio;
  logic               prio_mode, gen_hi, gen_lo, hi_active;
  logic [DEPTH_W-1:0] nest_depth;
  logic               hi_pend, lo_pend, any_pend;
  irq_lvl_e           sel_lvl;
  irq_lvl_e           lvl_q;
  logic               req_q;
  logic [VEC_W-1:0]   vec_q;
  logic               take, wr_ctrl;

  function automatic logic [VEC_W-1:0] vec_of(input irq_lvl_e lvl);
    return (lvl == LVL_HI) ? HI_VEC : LO_VEC;
  endfunction

  assign take    = irq_ack && req_q;
  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);

  irq_src_bank #(.NSRC(NSRC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .flags_q   (flags),
    .enab_q    (enab),
    .prio_q    (prio)
  );

  irq_arbiter #(.N_CORE(N_CORE), .N_PERIPH(N_PERIPH)) u_arb (
    .flags     (flags),
    .enab      (enab),
    .prio      (prio),
    .prio_mode (prio_mode),
    .gen_hi    (gen_hi),
    .gen_lo    (gen_lo),
    .hi_active (hi_active),
    .hi_pend   (hi_pend),
    .lo_pend   (lo_pend),
    .any_pend  (any_pend),
    .sel_lvl   (sel_lvl)
  );

  irq_nest_ctrl u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .ctrl_data (wr_data[2:0]),
    .take      (take),
    .take_lvl  (lvl_q),
    .ret       (irq_ret),
    .prio_mode (prio_mode),
    .gen_hi    (gen_hi),
    .gen_lo    (gen_lo),
    .hi_active (hi_active),
    .depth     (nest_depth)
  );

  // Vector and level reload only when no request is standing or one is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= LVL_LO;
      vec_q <= '0;
    end else begin
      req_q <= any_pend && !take;
      if (!req_q || take) begin
        lvl_q <= sel_lvl;
        vec_q <= vec_of(sel_lvl);
      end
    end
  end

  assign irq_req   = req_q;
  assign irq_vec   = vec_q;
  assign irq_level = (lvl_q == LVL_HI);
  assign flags_o   = flags;
  assign glb_en_o  = {gen_lo, gen_hi};

endmodule

// File: rtl/irq_checker.sv
module irq_checker
  import irq_pkg::*;
#(
  parameter int               NSRC   = 8,
  parameter int               VEC_W  = 24,
  parameter logic [VEC_W-1:0] HI_VEC = 24'h000008,
  parameter logic [VEC_W-1:0] LO_VEC = 24'h000018
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NSRC-1:0]    src_pulse,
  input logic [NSRC-1:0]    flags_o,
  input logic               irq_ack,
  input logic               irq_ret,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               irq_level,
  input logic [1:0]         glb_en_o,
  input logic               prio_mode,
  input logic               hi_active,
  input logic [DEPTH_W-1:0] nest_depth
);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flags_o & $past(src_pulse)) == $past(src_pulse))) // R2
    else $error("pulse did not leave its flag set");

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((irq_vec == HI_VEC && irq_level) || (irq_vec == LO_VEC && !irq_level))) // R5
    else $error("vector does not match level");

  AST_COMPAT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !$past(irq_req) && !$past(prio_mode)) |-> (irq_vec == HI_VEC)) // R4
    else $error("compatibility request not at upper vector");

  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (!irq_req || ($stable(irq_vec) && $stable(irq_level)))) // R7
    else $error("vector moved while request was standing");

  AST_ACK_HI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_level && !irq_ret) |=> !glb_en_o[0]) // R8
    else $error("upper enable not cleared on take");

  AST_ACK_LO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !irq_level && !irq_ret) |=> !glb_en_o[1]) // R8
    else $error("lower enable not cleared on take");

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req) // R10
    else $error("request stayed high after acknowledge");

  AST_NO_LOW_OVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !$past(irq_req) && $past(hi_active)) |-> irq_level) // R9
    else $error("low request raised during high handler");

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= DEPTH_W'(NEST_DEPTH)) // R9
    else $error("nesting record overflow");

endmodule

bind prio_irq_ctrl irq_checker #(
  .NSRC   (NSRC),
  .VEC_W  (VEC_W),
  .HI_VEC (HI_VEC),
  .LO_VEC (LO_VEC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_pulse  (src_pulse),
  .flags_o    (flags_o),
  .irq_ack    (irq_ack),
  .irq_ret    (irq_ret),
  .irq_req    (irq_req),
  .irq_vec    (irq_vec),
  .irq_level  (irq_level),
  .glb_en_o   (glb_en_o),
  .prio_mode  (prio_mode),
  .hi_active  (hi_active),
  .nest_depth (nest_depth)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

  localparam int NC = 2;
  localparam int NP = 2;
  localparam int NS = NC + NP;
  localparam int VW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_pulse = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [NS-1:0] wr_data = '0;
  logic          irq_ack = 1'b0;
  logic          irq_ret = 1'b0;
  logic          irq_req;
  logic [VW-1:0] irq_vec;
  logic          irq_level;
  logic [NS-1:0] flags_o;
  logic [1:0]    glb_en_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.N_CORE(NC), .N_PERIPH(NP), .VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_level(irq_level),
    .flags_o(flags_o), .glb_en_o(glb_en_o)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] p);
    src_pulse = p;
    tick();
    src_pulse = '0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1: reset state
    chk("R1 req", 32'(irq_req), 0);
    chk("R1 flags", 32'(flags_o), 0);
    chk("R1 glb", 32'(glb_en_o), 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 req after release", 32'(irq_req), 0);

    // R2: pulse beats a clearing write in the same cycle
    pulse(4'b0011);
    chk("R2 set", 32'(flags_o), 32'h3);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = '0; src_pulse = 4'b0001;
    tick();
    wr_en = 1'b0; src_pulse = '0;
    chk("R2 clear vs pulse", 32'(flags_o), 32'h1);
    tick(3);
    chk("R2 sticky", 32'(flags_o), 32'h1);
    wr(2'd1, '0);
    chk("R2 cleared", 32'(flags_o), 0);

    // R3 R4 R5: sweep one flagged source over every setting
    for (int m = 0; m < 2; m++)
      for (int g = 0; g < 4; g++)
        for (int s = 0; s < NS; s++)
          for (int p = 0; p < 2; p++)
            for (int e = 0; e < 2; e++) begin
              logic exp_req;
              logic [VW-1:0] exp_vec;
              string tg;
              tg = (m != 0) ? "R5" : "R4";
              if (m != 0) exp_req = (e != 0) && ((p != 0) ? g[0] : g[1]);
              else        exp_req = (e != 0) && g[0] && ((s < NC) || g[1]);
              exp_vec = ((m != 0) && (p == 0)) ? 24'h000018 : 24'h000008;
              wr(2'd2, NS'(e << s));
              wr(2'd3, NS'(p << s));
              wr(2'd0, NS'(m | (g << 1)));
              pulse(NS'(1 << s));
              chk("R2 flag", 32'(flags_o[s]), 1);
              tick();
              chk({tg, " R3 req"}, 32'(irq_req), 32'(exp_req));
              if (exp_req) chk({tg, " vec"}, 32'(irq_vec), 32'(exp_vec));
              wr(2'd0, '0);
              wr(2'd1, '0);
              tick();
              chk("R3 idle", 32'(irq_req), 0);
            end

    // R6: both levels pending together
    wr(2'd2, 4'b0011);
    wr(2'd3, 4'b0001);
    wr(2'd0, 4'b0111);
    pulse(4'b0011);
    tick();
    chk("R6 req", 32'(irq_req), 1);
    chk("R6 vec", 32'(irq_vec), 32'h8);
    chk("R6 level", 32'(irq_level), 1);

    // R8 R9: high handler blocks low
    ack();
    chk("R8 hi cleared", 32'(glb_en_o), 32'h2);
    chk("R10 drop", 32'(irq_req), 0);
    tick(2);
    chk("R9 low blocked", 32'(irq_req), 0);
    wr(2'd1, 4'b0010);
    ret();
    chk("R8 hi restored", 32'(glb_en_o), 32'h3);
    tick();
    chk("R9 low after ret", 32'(irq_req), 1);
    chk("R9 low vec", 32'(irq_vec), 32'h18);

    // R9: high pre-empts low handler, returns unwind in order
    ack();
    chk("R8 lo cleared", 32'(glb_en_o), 32'h1);
    pulse(4'b0001);
    tick();
    chk("R9 preempt req", 32'(irq_req), 1);
    chk("R9 preempt vec", 32'(irq_vec), 32'h8);
    ack();
    chk("R9 both cleared", 32'(glb_en_o), 32'h0);
    wr(2'd1, 4'b0010);
    ret();
    chk("R9 first ret", 32'(glb_en_o), 32'h1);
    wr(2'd1, 4'b0000);
    ret();
    chk("R9 second ret", 32'(glb_en_o), 32'h3);
    tick(2);
    chk("R9 idle", 32'(irq_req), 0);

    // R7: vector holds while request stands
    pulse(4'b0010);
    tick();
    chk("R7 low req", 32'(irq_req), 1);
    chk("R7 low vec", 32'(irq_vec), 32'h18);
    pulse(4'b0001);
    tick();
    chk("R7 still req", 32'(irq_req), 1);
    chk("R7 held vec", 32'(irq_vec), 32'h18);
    ack();
    chk("R8 lo taken", 32'(glb_en_o), 32'h1);
    tick();
    chk("R9 hi next", 32'(irq_req), 1);
    chk("R9 hi vec", 32'(irq_vec), 32'h8);
    ack();
    wr(2'd1, 4'b0010);
    ret();
    wr(2'd1, 4'b0000);
    ret();
    chk("R8 unwound", 32'(glb_en_o), 32'h3);

    // R10 R4: request timing and compat take/return
    wr(2'd0, 4'b0010);
    wr(2'd2, 4'b0001);
    tick();
    pulse(4'b0001);
    chk("R10 not yet", 32'(irq_req), 0);
    tick();
    chk("R10 req", 32'(irq_req), 1);
    chk("R4 vec", 32'(irq_vec), 32'h8);
    ack();
    chk("R4 ack clears upper", 32'(glb_en_o), 32'h0);
    wr(2'd1, '0);
    ret();
    chk("R4 ret restores upper", 32'(glb_en_o), 32'h1);
    tick(2);
    chk("R4 idle", 32'(irq_req), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule